// File: doc/BRIEF.md
# Run/Stop Switch Mode Controller with Fault-Clear Toggle

This block decides the operating mode of a controller from a two-position Run/Stop selector that has already been debounced. It produces one of three modes: Stop, Run, or Stop/Fault. A new fatal fault always forces Stop/Fault. While no fatal fault is pending, the selector moves the controller between Stop and Run. A fault that is not fatal does not reach this block, so it never stops the controller from entering Run.

In Stop/Fault, turning the selector to Run opens a fault-clear window and asks for the Run indicator to blink. The operator clears the faults by holding Run for a minimum dwell, then holding Stop for a minimum dwell, and then returning to Run, all inside the window. When that toggle completes, the block emits a one-cycle clear-fault-tables pulse and enters Run. The blink ends and the Run indicator stays on. If the window runs out first, the blink ends, the indicator goes dark and the faults stay.

Timing comes from a periodic tick input. The window length and the dwell length are parameters counted in ticks. With a 1 ms tick the defaults give 5 s and 0.5 s.

Top module: `mode_switch_ctrl`

## Requirements
- R1: When reset is released, mode_o is Stop (2'b00), clr_pulse is 0, led_blink is 0 and led_run is 0.
- R2: In Stop, with sw_en high and fatal_flt low, a change of sw_run from 0 to 1 enters Run (2'b01) without a clr_pulse.
- R3: In Run, with sw_en high, a change of sw_run from 1 to 0 enters Stop.
- R4: A rising edge on fatal_flt in Stop or Run enters Stop/Fault (2'b10).
- R5: In Stop/Fault with no window open, a change of sw_run from 0 to 1 opens the window: led_blink goes to 1 and the mode stays Stop/Fault.
- R6: A completed toggle inside the window clears the faults. The toggle is Run for at least DWELL_TICKS ticks, then Stop for at least DWELL_TICKS ticks, then back to Run. On completion clr_pulse is high for exactly one cycle, the mode becomes Run and led_blink drops.
- R7: The window closes on the WINDOW_TICKS-th tick after it opened. At that point led_blink drops, the mode stays Stop/Fault and no clr_pulse is produced.
- R8: A selector move that ends a dwell shorter than DWELL_TICKS spoils the attempt. No later toggle clears the faults in that window, and the window still closes at its original time.
- R9: After a window has closed, a new move of the selector to Run opens a fresh window.
- R10: A completing return to Run that falls in the same cycle as the window-closing tick counts as completed, and the clear wins.
- R11: With sw_en low, sw_run is ignored and any open window closes on the next clock edge.
- R12: led_run is 1 exactly when mode_o is Run. The encoding 2'b11 never appears on mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timing tick (nominally every 1 ms) |
| sw_run | input | 1 | Debounced selector position, 1 = Run, 0 = Stop |
| sw_en | input | 1 | Selector mode control enable (tie high for the default behaviour) |
| fatal_flt | input | 1 | Level flag, high while a fatal fault is logged |
| mode_o | output | 2 | Operating mode: 00 Stop, 01 Run, 10 Stop/Fault |
| clr_pulse | output | 1 | One-cycle request to clear the fault tables |
| led_blink | output | 1 | Run indicator blink request (window open) |
| led_run | output | 1 | Run indicator steady on |

## Verification
Two events can land in the same clock cycle: the operator's completing return to Run, and the tick that would close the window. The bench provokes this by counting ticks from the window's opening edge. It arranges for the return to Run to be sampled on exactly the WINDOW_TICKS-th tick. It then expects the clear pulse and Run mode, not a silent close. A second case pairs a spoiled attempt with a toggle that would otherwise be valid. That case confirms the window still closes on its original tick count.

// File: rtl/mode_sw_pkg.sv
package mode_sw_pkg;
  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_RUN   = 2'b01,
    MODE_FAULT = 2'b10
  } op_mode_e;

  typedef enum logic [1:0] {
    WIN_IDLE,
    WIN_HOLD_RUN,
    WIN_HOLD_STOP,
    WIN_SPOILED
  } win_phase_e;
endpackage

// File: rtl/sw_dwell_track.sv
module sw_dwell_track #(
  parameter int DWELL_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sw_in,
  output logic sw_rise,
  output logic sw_fall,
  output logic dwell_met
);
  localparam int W = $clog2(DWELL_TICKS + 1);
  localparam logic [W-1:0] DW_MAX = W'(DWELL_TICKS);

  logic         sw_q;
  logic [W-1:0] cnt;

  // sw_q resets to Run so that a selector already in Run at reset is not an edge
  assign sw_rise   = sw_in & ~sw_q;
  assign sw_fall   = ~sw_in & sw_q;
  assign dwell_met = (cnt == DW_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q <= 1'b1;
      cnt  <= '0;
    end else begin
      sw_q <= sw_in;
      if (sw_rise || sw_fall)
        cnt <= '0;
      else if (tick && cnt != DW_MAX)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int WINDOW_TICKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic cancel,
  output logic expire
);
  localparam int W = (WINDOW_TICKS > 2) ? $clog2(WINDOW_TICKS) : 1;
  localparam logic [W-1:0] LAST = W'(WINDOW_TICKS - 1);

  logic         active;
  logic [W-1:0] cnt;

  assign expire = active & tick & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (cancel || expire) begin
      active <= 1'b0;
    end else if (active && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mode_switch_ctrl.sv
module mode_switch_ctrl
  import mode_sw_pkg::*;
#(
  parameter int WINDOW_TICKS = 5000,
  parameter int DWELL_TICKS  = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sw_run,
  input  logic       sw_en,
  input  logic       fatal_flt,
  output logic [1:0] mode_o,
  output logic       clr_pulse,
  output logic       led_blink,
  output logic       led_run
);
  op_mode_e   mode_q, mode_d;
  win_phase_e phase_q, phase_d;
  logic       clr_q, clr_d;
  logic       fatal_q;
  logic       sw_rise, sw_fall, dwell_met;
  logic       win_start, win_cancel, win_expire;
  logic       fatal_new;

  sw_dwell_track #(.DWELL_TICKS(DWELL_TICKS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sw_in     (sw_run),
    .sw_rise   (sw_rise),
    .sw_fall   (sw_fall),
    .dwell_met (dwell_met)
  );

  window_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .start  (win_start),
    .cancel (win_cancel),
    .expire (win_expire)
  );

  assign fatal_new = fatal_flt & ~fatal_q;

  always_comb begin
    mode_d     = mode_q;
    phase_d    = phase_q;
    clr_d      = 1'b0;
    win_start  = 1'b0;
    win_cancel = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (fatal_new)             mode_d = MODE_FAULT;
        else if (sw_en && sw_fall) mode_d = MODE_STOP;
      end
      MODE_STOP: begin
        if (fatal_new)                             mode_d = MODE_FAULT;
        else if (sw_en && sw_rise && !fatal_flt)   mode_d = MODE_RUN;
      end
      MODE_FAULT: begin
        if (!sw_en) begin
          phase_d    = WIN_IDLE;
          win_cancel = (phase_q != WIN_IDLE);
        end else begin
          case (phase_q)
            WIN_IDLE: begin
              if (sw_rise) begin
                phase_d   = WIN_HOLD_RUN;
                win_start = 1'b1;
              end
            end
            WIN_HOLD_RUN: begin
              if (win_expire)   phase_d = WIN_IDLE;
              else if (sw_fall) phase_d = dwell_met ? WIN_HOLD_STOP : WIN_SPOILED;
            end
            WIN_HOLD_STOP: begin
              // a completing edge beats a coincident expiry
              if (sw_rise && dwell_met) begin
                mode_d     = MODE_RUN;
                phase_d    = WIN_IDLE;
                clr_d      = 1'b1;
                win_cancel = 1'b1;
              end else if (win_expire) begin
                phase_d = WIN_IDLE;
              end else if (sw_rise) begin
                phase_d = WIN_SPOILED;
              end
            end
            default: begin
              if (win_expire) phase_d = WIN_IDLE;
            end
          endcase
        end
      end
      default: mode_d = MODE_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_STOP;
      phase_q <= WIN_IDLE;
      clr_q   <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
      clr_q   <= clr_d;
      fatal_q <= fatal_flt;
    end
  end

  assign mode_o    = mode_q;
  assign clr_pulse = clr_q;
  assign led_blink = (phase_q != WIN_IDLE);
  assign led_run   = (mode_q == MODE_RUN);
endmodule

// File: rtl/mode_switch_ctrl_chk.sv
module mode_switch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_run,
  input logic       sw_en,
  input logic       fatal_flt,
  input logic [1:0] mode_o,
  input logic       clr_pulse,
  input logic       led_blink
);
  localparam logic [1:0] C_STOP  = 2'b00;
  localparam logic [1:0] C_RUN   = 2'b01;
  localparam logic [1:0] C_FAULT = 2'b10;

  p_legal_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  p_blink_in_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    led_blink |-> mode_o == C_FAULT);

  p_clear_from_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> ($past(led_blink) && $past(mode_o) == C_FAULT && mode_o == C_RUN));

  p_clear_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);

  p_fatal_enters_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_flt && !$past(fatal_flt) && mode_o != C_FAULT) |=> mode_o == C_FAULT);

  p_run_to_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == C_RUN && sw_en && !sw_run && $past(sw_run) &&
     !(fatal_flt && !$past(fatal_flt))) |=> mode_o == C_STOP);

  p_disable_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !led_blink);
endmodule

bind mode_switch_ctrl mode_switch_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_run    (sw_run),
  .sw_en     (sw_en),
  .fatal_flt (fatal_flt),
  .mode_o    (mode_o),
  .clr_pulse (clr_pulse),
  .led_blink (led_blink)
);

// File: tb/mode_switch_ctrl_tb.sv
module mode_switch_ctrl_tb;
  localparam int WIN = 40;
  localparam int DW  = 8;
  localparam logic [1:0] M_STOP = 2'b00, M_RUN = 2'b01, M_FLT = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic sw_run = 1'b0, sw_en = 1'b1, fatal_flt = 1'b0;
  logic [1:0] mode_o;
  logic clr_pulse, led_blink, led_run;

  int errors = 0, checks = 0, tick_seen = 0, edge_ref = 0;
  logic [1:0] tdiv = 2'd0;
  bit done = 1'b0, mon_on = 1'b0;
  logic [4:0] last_obs;
  logic [4:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  mode_switch_ctrl #(.WINDOW_TICKS(WIN), .DWELL_TICKS(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_run(sw_run), .sw_en(sw_en),
    .fatal_flt(fatal_flt), .mode_o(mode_o), .clr_pulse(clr_pulse),
    .led_blink(led_blink), .led_run(led_run)
  );

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd2);
  end

  always @(posedge clk) if (tick) tick_seen <= tick_seen + 1;

  function automatic logic [4:0] st(logic [1:0] m, logic c, logic b, logic l);
    return {m, c, b, l};
  endfunction

  task automatic push(logic [4:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: every change of the output tuple is matched against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      logic [4:0] obs;
      obs = {mode_o, clr_pulse, led_blink, led_run};
      if (obs !== last_obs) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R12 unexpected change got %b expected %b", obs, last_obs);
        end else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (obs !== e) begin
            errors++;
            $display("FAIL %s got %b expected %b", t, obs, e);
          end
        end
        last_obs = obs;
      end
    end
  end

  task automatic drive_sw(logic v);
    @(negedge clk);
    sw_run = v;
    @(posedge clk);
    #1;
    edge_ref = tick_seen;
  endtask

  task automatic wait_ticks(int n);
    int t0;
    t0 = tick_seen;
    wait (tick_seen >= t0 + n);
  endtask

  task automatic set_fatal(logic v);
    @(negedge clk);
    fatal_flt = v;
  endtask

  function automatic logic [4:0] now_obs();
    return {mode_o, clr_pulse, led_blink, led_run};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int ref_t;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", now_obs(), st(M_STOP, 0, 0, 0));
    last_obs = now_obs();
    mon_on = 1'b1;

    // R2 / R3 plain selector moves
    push(st(M_RUN, 0, 0, 1), "R2 stop to run");
    drive_sw(1'b1); wait_ticks(3);
    push(st(M_STOP, 0, 0, 0), "R3 run to stop");
    drive_sw(1'b0); wait_ticks(3);
    push(st(M_RUN, 0, 0, 1), "R2 stop to run again");
    drive_sw(1'b1); wait_ticks(2);

    // R4 fatal fault while running
    push(st(M_FLT, 0, 0, 0), "R4 fatal enters fault");
    set_fatal(1'b1); wait_ticks(2);
    drive_sw(1'b0); wait_ticks(2);

    // R5 / R6 valid toggle
    push(st(M_FLT, 0, 1, 0), "R5 window opens");
    drive_sw(1'b1); wait_ticks(DW + 1);
    drive_sw(1'b0); wait_ticks(DW + 1);
    push(st(M_RUN, 1, 0, 1), "R6 clear pulse");
    push(st(M_RUN, 0, 0, 1), "R6 pulse ends");
    drive_sw(1'b1);
    set_fatal(1'b0); wait_ticks(2);

    // R7 window expiry
    push(st(M_FLT, 0, 0, 0), "R4 fatal from run");
    set_fatal(1'b1); wait_ticks(2);
    drive_sw(1'b0); wait_ticks(2);
    push(st(M_FLT, 0, 1, 0), "R5 window opens");
    drive_sw(1'b1); ref_t = edge_ref;
    wait (tick_seen == ref_t + WIN - 1); @(negedge clk);
    check("R7 blink before last tick", now_obs(), st(M_FLT, 0, 1, 0));
    push(st(M_FLT, 0, 0, 0), "R7 expiry");
    wait (tick_seen == ref_t + WIN); @(negedge clk);
    check("R7 closed on last tick", now_obs(), st(M_FLT, 0, 0, 0));
    wait_ticks(2);

    // R9 reopen, R8 spoiled attempt
    drive_sw(1'b0); wait_ticks(2);
    push(st(M_FLT, 0, 1, 0), "R9 window reopens");
    drive_sw(1'b1); ref_t = edge_ref;
    wait_ticks(DW - 3);
    drive_sw(1'b0); wait_ticks(DW + 1);
    drive_sw(1'b1);
    wait (tick_seen == ref_t + WIN - 1); @(negedge clk);
    check("R8 spoiled no clear, still open", now_obs(), st(M_FLT, 0, 1, 0));
    push(st(M_FLT, 0, 0, 0), "R8 original expiry");
    wait (tick_seen == ref_t + WIN); @(negedge clk);
    check("R8 closed at original time", now_obs(), st(M_FLT, 0, 0, 0));
    wait_ticks(2);

    // R10 completion on the expiring tick
    drive_sw(1'b0); wait_ticks(2);
    push(st(M_FLT, 0, 1, 0), "R10 window opens");
    drive_sw(1'b1); ref_t = edge_ref;
    wait_ticks(DW + 1);
    drive_sw(1'b0);
    wait (tick_seen == ref_t + WIN - 1);
    forever begin
      @(negedge clk); #1;
      if (tick) break;
    end
    push(st(M_RUN, 1, 0, 1), "R10 clear wins over expiry");
    push(st(M_RUN, 0, 0, 1), "R10 pulse ends");
    sw_run = 1'b1;
    @(posedge clk); #1;
    check("R10 tick coincided", 5'(tick_seen - ref_t), 5'(WIN));
    set_fatal(1'b0); wait_ticks(2);
    check("R10 in run", now_obs(), st(M_RUN, 0, 0, 1));

    // R11 enable low
    @(negedge clk); sw_en = 1'b0;
    drive_sw(1'b0); wait_ticks(2);
    check("R11 selector ignored in run", now_obs(), st(M_RUN, 0, 0, 1));
    drive_sw(1'b1);
    @(negedge clk); sw_en = 1'b1;
    push(st(M_FLT, 0, 0, 0), "R4 fatal again");
    set_fatal(1'b1); wait_ticks(2);
    drive_sw(1'b0); wait_ticks(2);
    push(st(M_FLT, 0, 1, 0), "R11 window opens");
    drive_sw(1'b1); wait_ticks(3);
    push(st(M_FLT, 0, 0, 0), "R11 disable closes window");
    @(negedge clk); sw_en = 1'b0;
    wait_ticks(2);
    check("R11 window closed", now_obs(), st(M_FLT, 0, 0, 0));
    drive_sw(1'b0); drive_sw(1'b1); wait_ticks(2);
    check("R11 no window while disabled", now_obs(), st(M_FLT, 0, 0, 0));
    check("R12 led_run off in fault", {4'b0, led_run}, 5'b0);

    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12 pending changes got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule